// File: doc/BRIEF.md
# Timekeeping Snapshot Register Bank

This block holds a byte-wide readable copy of seven BCD time fields. A set of clock counters outside the block runs all the time. Once per second the block copies every field from those counters in a single clock edge, so software never sees a time that is partly updated. The copy is taken on the rising edge of a 1 Hz tick.

Software freezes the copy by setting a hold bit in a control byte, and then reads the time fields at its own pace. The external counters keep running while the copy is frozen. Clearing the hold bit refreshes the copy on the next clock cycle, so the fields are current again at once instead of after up to a second. A hold request that lands on the same cycle as a copy lets that copy finish first.

Top module: `rtc_snap_top`

## Requirements
- R1: After synchronous reset, all seven held fields and the hold bit are 0, so every offset reads 0x00.
- R2: When `tick_1hz` is sampled high at a rising clock edge after being low at the previous edge, and the hold bit is 0, all seven held fields load the counter values present at that same edge.
- R3: While the hold bit is 1, tick edges do not change any held field, whatever the counters do.
- R4: A write that sets the hold bit on the same clock edge as a tick-derived copy does not cancel that copy. The fields take the counter values of that edge, and the hold bit reads 1 afterwards.
- R5: A write of 0 to the hold bit while it is 1 causes a catch-up copy one clock edge after the write edge, with no tick needed. Between the write edge and that edge the fields still show their old values.
- R6: The read is combinational on `addr`. Offset 0 is the control byte, and offsets 1 to 7 are seconds, minutes, hours, weekday, day of month, month and year, in that order.
- R7: Bits that a field does not use read as 0. Seconds and minutes use bits 6:0, hours and day of month use bits 5:0, weekday uses bits 2:0, month uses bits 4:0 and year uses bits 7:0. In the control byte only bit 6 (the hold bit) is readable.
- R8: Writes to offsets 1 to 7 change nothing. A control write stores only bit 6 and ignores the other bits.
- R9: A tick held high for several cycles causes only one copy, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | 1 Hz tick; copy taken on its rising edge |
| cnt_fields | input | 56 | Live counter fields, field i at bits 8i+7:8i (0 = seconds ... 6 = year) |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
Two functions can fall on the same clock edge: the tick-driven copy and a control write that sets the hold bit. The bench raises the tick and writes the hold bit in the same cycle. It then judges the result by reading back every field, which must match the counters of that edge, and then by confirming that the hold bit is set and that a later tick leaves the fields frozen. The release path is also tested with counters that changed during the hold. The bench reads the old values between the write edge and the catch-up edge, and the new values afterwards.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = 3;
    localparam int HALT_BIT   = 6;
    localparam int BUS_W      = FIELD_W * NUM_FIELDS;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL = 3'd0,
        OFS_SEC  = 3'd1,
        OFS_MIN  = 3'd2,
        OFS_HOUR = 3'd3,
        OFS_WDAY = 3'd4,
        OFS_MDAY = 3'd5,
        OFS_MON  = 3'd6,
        OFS_YEAR = 3'd7
    } reg_ofs_e;

    typedef logic [FIELD_W-1:0]                  field_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0]  time_vec_t;

    typedef struct packed {
        logic halt;
        logic catchup;
    } ctrl_state_t;

    // Valid-bit mask of time field idx (0 = seconds ... 6 = year)
    function automatic field_t field_mask(input int idx);
        field_t m;
        case (idx)
            0, 1:    m = 8'h7F;
            2, 4:    m = 8'h3F;
            3:       m = 8'h07;
            5:       m = 8'h1F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rtc_snap_strobe.sv
module rtc_snap_strobe
    import rtc_snap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic strobe
);
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick;
    end

    assign strobe = tick & ~tick_q;
endmodule

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
    import rtc_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  field_t            wdata,
    output ctrl_state_t       state
);
    logic ctrl_hit;
    logic req_halt;

    assign ctrl_hit = wr_en && (addr == OFS_CTRL);
    assign req_halt = wdata[HALT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            state.catchup <= ctrl_hit && state.halt && !req_halt;
            if (ctrl_hit) state.halt <= req_halt;
        end
    end
endmodule

// File: rtl/rtc_snap_hold.sv
module rtc_snap_hold
    import rtc_snap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  ctrl_state_t state,
    input  time_vec_t   cnt,
    output time_vec_t   held
);
    logic load;

    // halt is the registered value: a halt written on the strobe edge
    // takes effect only after this copy completes
    assign load = (strobe && !state.halt) || state.catchup;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)       held[i] <= '0;
            else if (load) held[i] <= cnt[i] & field_mask(i);
        end
    end
endmodule

// File: rtl/rtc_snap_rdmux.sv
module rtc_snap_rdmux
    import rtc_snap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              halt,
    input  time_vec_t         held,
    output field_t            rdata
);
    int sel;

    always_comb begin
        sel   = int'(addr);
        rdata = '0;
        if (sel == 0) begin
            rdata[HALT_BIT] = halt;
        end else if (sel <= NUM_FIELDS) begin
            rdata = held[sel-1] & field_mask(sel-1);
        end
    end
endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
    import rtc_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [BUS_W-1:0]  cnt_fields,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] rdata
);
    logic        strobe;
    ctrl_state_t state;
    time_vec_t   cnt_vec;
    time_vec_t   held;

    assign cnt_vec = time_vec_t'(cnt_fields);

    rtc_snap_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .strobe (strobe)
    );

    rtc_snap_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .state (state)
    );

    rtc_snap_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .state  (state),
        .cnt    (cnt_vec),
        .held   (held)
    );

    rtc_snap_rdmux u_rdmux (
        .addr  (addr),
        .halt  (state.halt),
        .held  (held),
        .rdata (rdata)
    );
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk
    import rtc_snap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              strobe,
    input ctrl_state_t       state,
    input time_vec_t         cnt_vec,
    input time_vec_t         held,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input field_t            wdata,
    input field_t            rdata
);
    time_vec_t cnt_m;
    field_t    rd_mask;
    logic      ctrl_wr;

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) cnt_m[i] = cnt_vec[i] & field_mask(i);
        rd_mask = (addr == OFS_CTRL) ? field_t'(1 << HALT_BIT) : field_mask(int'(addr) - 1);
    end

    assign ctrl_wr = wr_en && (addr == OFS_CTRL);

    assert_tick_copy_R2: assert property (@(posedge clk) disable iff (rst)
        (strobe && !state.halt) |=> (held == $past(cnt_m)));

    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (state.halt && !state.catchup) |=> $stable(held));

    assert_halt_same_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !state.halt && ctrl_wr && wdata[HALT_BIT])
        |=> (state.halt && held == $past(cnt_m)));

    assert_release_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && state.halt && !wdata[HALT_BIT]) |=> state.catchup);

    assert_release_copy_R5: assert property (@(posedge clk) disable iff (rst)
        state.catchup |=> (held == $past(cnt_m)));

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((rdata & ~rd_mask) == '0));

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

bind rtc_snap_top rtc_snap_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .state   (state),
    .cnt_vec (cnt_vec),
    .held    (held),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata)
);

// File: tb/rtc_snap_top_tb.sv
module rtc_snap_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_1hz;
    logic [55:0] cnt_bus;
    logic        wr_en;
    logic [2:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    logic [7:0] exp_f [7];
    logic       exp_halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_snap_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick_1hz   (tick_1hz),
        .cnt_fields (cnt_bus),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata)
    );

    // valid bits per field, from R7
    function automatic logic [7:0] msk(input int i);
        case (i)
            0: return 8'h7F; 1: return 8'h7F; 2: return 8'h3F;
            3: return 8'h07; 4: return 8'h3F; 5: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] expect_at(input int a);
        if (a == 0) return {1'b0, exp_halt, 6'b0};
        return exp_f[a-1] & msk(a-1);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // R6 offset order and R7 masks are checked on every read here
    task automatic check_reg(input string tag, input int a);
        @(negedge clk);
        addr = 3'(a);
        #1;
        check(tag, rdata, expect_at(a));
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) check_reg(tag, a);
    endtask

    task automatic latch_exp();
        for (int i = 0; i < 7; i++) exp_f[i] = cnt_bus[8*i +: 8];
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        if (!exp_halt) latch_exp();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [55:0] pattern(input int v);
        logic [55:0] p;
        for (int i = 0; i < 7; i++) p[8*i +: 8] = 8'(v ^ (i * 37));
        return p;
    endfunction

    initial begin
        rst = 1'b1; tick_1hz = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        cnt_bus = 56'h13_57_9B_DF_24_68_AC;
        exp_halt = 1'b0;
        for (int i = 0; i < 7; i++) exp_f[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1");

        // R2 sweep: every byte value on every field, masked on read (R7)
        for (int v = 0; v < 256; v++) begin
            cnt_bus = pattern(v);
            tick_pulse();
            check_all("R2");
        end

        // R9: tick held high, counters change, only the first value is held
        cnt_bus = pattern(17);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); cnt_bus = pattern(99);
        repeat (3) @(negedge clk);
        tick_1hz = 1'b0;
        for (int i = 0; i < 7; i++) exp_f[i] = pattern(17)[8*i +: 8];
        check_all("R9");

        // R4: hold written on the same edge as the tick copy
        cnt_bus = pattern(201);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h40;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        latch_exp();
        exp_halt = 1'b1;
        check_all("R4");

        // R3: frozen across ticks with moving counters
        for (int k = 0; k < 4; k++) begin
            cnt_bus = pattern(50 + k);
            tick_pulse();
            check_all("R3");
        end

        // R5: release -> old values until the catch-up edge, then new
        cnt_bus = pattern(123);
        wr(3'd0, 8'h00);
        exp_halt = 1'b0;
        addr = 3'd1; #1;
        check("R5 before catch-up", rdata, expect_at(1));
        @(negedge clk);
        latch_exp();
        check_all("R5");

        // R8: writes to time offsets are ignored
        for (int a = 1; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            check_reg("R8", a);
        end
        // R8: only bit 6 of a control write is stored
        wr(3'd0, 8'hBF);
        check_reg("R8 ctrl", 0);
        cnt_bus = pattern(77);
        tick_pulse();
        check_all("R8 not halted");

        // R3/R5 repeated over several hold/release rounds
        for (int r = 0; r < 8; r++) begin
            wr(3'd0, 8'h40);
            exp_halt = 1'b1;
            cnt_bus = pattern(300 + r);
            tick_pulse();
            check_all("R3 round");
            wr(3'd0, 8'h00);
            exp_halt = 1'b0;
            @(negedge clk);
            latch_exp();
            check_all("R5 round");
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            wait (done);
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule